// File: doc/BRIEF.md
# SDRAM Command Timing Controller

This block sits between a simple host request port and a single-data-rate SDRAM device. It turns single-word read and write requests into the memory's command stream: activate, read, write, single-bank precharge, precharge-all, auto-refresh, mode-register write, and self-refresh entry and exit. It keeps at most one open row per internal bank. A request to a different row in an open bank first closes that bank, and then reopens it on the new row.

Every command spacing, the column width and the bank count come from a packed 16-bit control word that may be changed at run time. The controller stays silent after reset until a start pulse launches the initialisation sequence. It then serves host accesses in order, inserts auto-refresh at a programmable interval, and enters and leaves self refresh on a level request. All delays are counted in memory clock ticks. A ratio bit makes the memory clock equal to the core clock, or half of it.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset, `cmd` is 0 (no-op), and `req_ack`, `rd_valid` and `init_done` are 0. Before `init_go` is pulsed, no command other than no-op appears. Command codes: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge bank, 5 precharge all, 6 auto-refresh, 7 mode write, 8 self-refresh enter, 9 self-refresh exit.
- R2: A pulse on `init_go` produces the following, in order: precharge-all; auto-refresh after tRP ticks; a second auto-refresh REF_GAP ticks later; and a mode write REF_GAP ticks after that. The mode write carries the effective CAS latency in `row[6:4]`. `init_done` rises with the mode write.
- R3: Control word layout: `ctrl[1:0]` CAS latency, `ctrl[5:2]` tRAS, `ctrl[8:6]` tRP, `ctrl[11:9]` tRCD, `ctrl[13:12]` page code, `ctrl[14]` four-bank select, `ctrl[15]` half-rate select. A tRP, tRCD or CAS code of 0 acts as 1.
- R4: Address split. The column is the low 8+page-code address bits. The bank is the next 2 bits when `ctrl[14]`=1, or the next 1 bit when it is 0. The row is the bits above the bank.
- R5: An access to a closed bank issues activate, then the read or write exactly tRCD ticks later.
- R6: An access to the open row of its bank issues only the read or write, with no activate or precharge.
- R7: An access to another row of an open bank issues precharge of that bank, then activate tRP ticks later, then the read or write tRCD ticks later. The precharge comes no sooner than tRAS ticks after that bank's activate.
- R8: `rd_valid` pulses once, CAS-latency ticks after each read command. It does not pulse for writes.
- R9: With the half-rate bit set, commands appear only on alternate core cycles, and every tick-counted delay doubles in core cycles.
- R10: A `ref_interval` of 0 produces no auto-refresh. A pending refresh is served before a waiting host request: precharge-all while rows are open, then auto-refresh tRP ticks later.
- R11: `req_ack` is a one-cycle pulse in the same cycle as the read or write command of the acknowledged request.
- R12: While `srf_req` is high, the controller closes open rows with precharge-all, issues self-refresh enter, and then holds no-op with `self_ref_active` high. When `srf_req` falls, it issues self-refresh exit and resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 16 | Packed timing and geometry control word |
| ref_interval | input | RI_W | Refresh interval in ticks, 0 disables |
| init_go | input | 1 | Starts the power-up sequence |
| srf_req | input | 1 | Level request for self refresh |
| req_valid | input | 1 | Host access request, held until acknowledged |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 13+ROW_W | Host word address |
| req_ack | output | 1 | Request accepted (read/write issued) |
| cmd | output | 4 | Memory command code |
| ba | output | 2 | Bank address |
| row | output | ROW_W | Row address or mode-register value |
| col | output | 11 | Column address |
| rd_valid | output | 1 | Read data valid strobe |
| init_done | output | 1 | Initialisation complete |
| self_ref_active | output | 1 | Device is held in self refresh |

## Verification
The bench builds the block with its default parameters: a 13-bit row, a REF_GAP of 4 ticks and a 16-bit refresh interval. The full 13-bit row reaches the top row address 0x1FFF. All timing and geometry variety comes through the run-time control word. The bench moves the CAS code across 0 to 3 and switches the page code from 256 to 2048 words, together with the 2-bank map. It lengthens tRAS beyond the activate-to-read path and toggles the half-rate bit, so that doubled spacings and the column, bank and row split under both geometries are all measured.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    localparam int COL_MAX_W = 11;
    localparam int BANK_W    = 2;
    localparam int NBANK     = 1 << BANK_W;

    typedef enum logic [3:0] {
        C_NOP = 4'd0, C_ACT = 4'd1, C_RD  = 4'd2, C_WR  = 4'd3, C_PRE = 4'd4,
        C_PALL = 4'd5, C_REF = 4'd6, C_MRS = 4'd7, C_SRE = 4'd8, C_SRX = 4'd9
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        S_BOOT, S_IPRE, S_IREF1, S_IREF2, S_IMRS,
        S_IDLE, S_ACT, S_RW, S_REF, S_SRE, S_SELF
    } sdr_state_e;

    typedef struct packed {
        logic       half_rate;
        logic       four_bank;
        logic [1:0] page;
        logic [2:0] trcd;
        logic [2:0] trp;
        logic [3:0] tras;
        logic [1:0] cas;
    } sdr_cfg_t;

    // load value for a wait counter so that the next command lands v ticks later
    function automatic logic [3:0] gap_load(input logic [3:0] v);
        return (v == 4'd0) ? 4'd0 : v - 4'd1;
    endfunction
endpackage

// File: rtl/sdr_tick.sv
module sdr_tick (
    input  logic clk,
    input  logic rst,
    input  logic half_i,
    output logic tick_o
);
    logic phase;
    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end
    assign tick_o = ~half_i | phase;

    p_half_skip_r9: assert property (@(posedge clk) disable iff (rst)
        (half_i && $past(half_i) && $past(tick_o)) |-> !tick_o);
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int RI_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            en,
    input  logic [RI_W-1:0] interval,
    input  logic            served,
    output logic            pending
);
    logic [RI_W-1:0] cnt;
    logic            fire;

    assign fire = tick && en && (interval != '0) && (cnt >= interval - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (tick) begin
                if (!en || interval == '0 || fire) cnt <= '0;
                else                               cnt <= cnt + 1'b1;
            end
            pending <= (pending && !served) || fire;
        end
    end

    p_pending_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (pending && !served) |=> pending);
endmodule

// File: rtl/sdr_bank_table.sv
module sdr_bank_table
    import sdr_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              act_en,
    input  logic              pre_en,
    input  logic              pall_en,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [3:0]        tras_i,
    output logic              hit_o,
    output logic              open_o,
    output logic              ras_ok_o,
    output logic              any_open_o,
    output logic              all_ok_o
);
    logic [NBANK-1:0] open_v, ok_v;
    logic [ROW_W-1:0] rows [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [3:0] ras;
        logic       sel;
        assign sel     = (bank_i == BANK_W'(b));
        assign ok_v[b] = (ras == 4'd0);

        always_ff @(posedge clk) begin
            if (rst) begin
                open_v[b] <= 1'b0;
                rows[b]   <= '0;
                ras       <= 4'd0;
            end else if (act_en && sel) begin
                open_v[b] <= 1'b1;
                rows[b]   <= row_i;
                ras       <= gap_load(tras_i);
            end else begin
                if (tick && ras != 4'd0) ras <= ras - 4'd1;
                if (pall_en || (pre_en && sel)) open_v[b] <= 1'b0;
            end
        end

        p_act_closed_r7: assert property (@(posedge clk) disable iff (rst)
            (act_en && sel) |-> !open_v[b]);
        p_pre_after_tras_r7: assert property (@(posedge clk) disable iff (rst)
            ((pre_en && sel) || pall_en) |-> (ras == 4'd0));
    end

    assign open_o     = open_v[bank_i];
    assign ras_ok_o   = ok_v[bank_i];
    assign hit_o      = open_v[bank_i] && (rows[bank_i] == row_i);
    assign any_open_o = |open_v;
    assign all_ok_o   = &ok_v;
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
    import sdr_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int REF_GAP = 4,
    parameter int RI_W    = 16,
    localparam int ADDR_W = COL_MAX_W + BANK_W + ROW_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [15:0]          ctrl,
    input  logic [RI_W-1:0]      ref_interval,
    input  logic                 init_go,
    input  logic                 srf_req,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 req_ack,
    output logic [3:0]           cmd,
    output logic [BANK_W-1:0]    ba,
    output logic [ROW_W-1:0]     row,
    output logic [COL_MAX_W-1:0] col,
    output logic                 rd_valid,
    output logic                 init_done,
    output logic                 self_ref_active
);
    localparam logic [3:0] REF_LOAD = 4'(REF_GAP - 1);

    sdr_cfg_t cfg;
    assign cfg = sdr_cfg_t'(ctrl);

    // address split
    logic [3:0]           cbits;
    logic [ADDR_W-1:0]    above_col, col_mask;
    logic [COL_MAX_W-1:0] a_col;
    logic [BANK_W-1:0]    a_bank;
    logic [ROW_W-1:0]     a_row;
    assign cbits     = 4'd8 + {2'b00, cfg.page};
    assign above_col = req_addr >> cbits;
    assign col_mask  = (ADDR_W'(1) << cbits) - ADDR_W'(1);
    assign a_col     = COL_MAX_W'(req_addr & col_mask);
    assign a_bank    = cfg.four_bank ? above_col[1:0] : {1'b0, above_col[0]};
    assign a_row     = ROW_W'(cfg.four_bank ? (above_col >> 2) : (above_col >> 1));

    logic [2:0] cl_eff;
    assign cl_eff = (cfg.cas == 2'd0) ? 3'd1 : {1'b0, cfg.cas};

    sdr_state_e state, n_state;
    sdr_cmd_e   cmd_q, n_cmd;
    logic [3:0] wait_q, n_wait;
    logic [BANK_W-1:0]    ba_q;
    logic [ROW_W-1:0]     row_q, n_row;
    logic [COL_MAX_W-1:0] col_q;
    logic ack_q, done_q, tick, go, ref_pend;
    logic hit, bopen, bok, any_open, all_ok;
    logic [2:0] rd_pipe;
    logic rdv_q;

    sdr_tick u_tick (.clk(clk), .rst(rst), .half_i(cfg.half_rate), .tick_o(tick));

    assign go = tick && (wait_q == 4'd0) && (state != S_BOOT);

    sdr_bank_table #(.ROW_W(ROW_W)) u_banks (
        .clk(clk), .rst(rst), .tick(tick),
        .act_en(go && n_cmd == C_ACT), .pre_en(go && n_cmd == C_PRE),
        .pall_en(go && n_cmd == C_PALL),
        .bank_i(a_bank), .row_i(a_row), .tras_i(cfg.tras),
        .hit_o(hit), .open_o(bopen), .ras_ok_o(bok),
        .any_open_o(any_open), .all_ok_o(all_ok)
    );

    sdr_refresh_timer #(.RI_W(RI_W)) u_refresh (
        .clk(clk), .rst(rst), .tick(tick),
        .en(done_q && state != S_SELF), .interval(ref_interval),
        .served(go && n_cmd == C_REF && (state == S_IDLE || state == S_REF)),
        .pending(ref_pend)
    );

    always_comb begin
        n_state = state;
        n_cmd   = C_NOP;
        n_wait  = 4'd0;
        n_row   = a_row;
        unique case (state)
            S_IPRE:  begin n_cmd = C_PALL; n_wait = gap_load({1'b0, cfg.trp}); n_state = S_IREF1; end
            S_IREF1: begin n_cmd = C_REF;  n_wait = REF_LOAD; n_state = S_IREF2; end
            S_IREF2: begin n_cmd = C_REF;  n_wait = REF_LOAD; n_state = S_IMRS; end
            S_IMRS:  begin
                n_cmd = C_MRS; n_wait = 4'd1; n_state = S_IDLE;
                n_row = '0; n_row[6:4] = cl_eff;
            end
            S_IDLE: begin
                if (srf_req || ref_pend) begin
                    if (any_open) begin
                        if (all_ok) begin
                            n_cmd   = C_PALL;
                            n_wait  = gap_load({1'b0, cfg.trp});
                            n_state = srf_req ? S_SRE : S_REF;
                        end
                    end else if (srf_req) begin
                        n_cmd = C_SRE; n_state = S_SELF;
                    end else begin
                        n_cmd = C_REF; n_wait = REF_LOAD;
                    end
                end else if (req_valid) begin
                    if (hit) begin
                        n_cmd = req_write ? C_WR : C_RD;
                    end else if (bopen) begin
                        if (bok) begin
                            n_cmd = C_PRE; n_wait = gap_load({1'b0, cfg.trp}); n_state = S_ACT;
                        end
                    end else begin
                        n_cmd = C_ACT; n_wait = gap_load({1'b0, cfg.trcd}); n_state = S_RW;
                    end
                end
            end
            S_ACT:  begin n_cmd = C_ACT; n_wait = gap_load({1'b0, cfg.trcd}); n_state = S_RW; end
            S_RW:   begin n_cmd = req_write ? C_WR : C_RD; n_state = S_IDLE; end
            S_REF:  begin n_cmd = C_REF; n_wait = REF_LOAD; n_state = S_IDLE; end
            S_SRE:  begin n_cmd = C_SRE; n_state = S_SELF; end
            S_SELF: if (!srf_req) begin n_cmd = C_SRX; n_wait = REF_LOAD; n_state = S_IDLE; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_BOOT;
            wait_q <= 4'd0;
            cmd_q  <= C_NOP;
            ba_q   <= '0;
            row_q  <= '0;
            col_q  <= '0;
            ack_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cmd_q <= C_NOP;
            ack_q <= 1'b0;
            if (state == S_BOOT) begin
                if (init_go) state <= S_IPRE;
            end else if (tick) begin
                if (wait_q != 4'd0) begin
                    wait_q <= wait_q - 4'd1;
                end else begin
                    state  <= n_state;
                    cmd_q  <= n_cmd;
                    wait_q <= n_wait;
                    ba_q   <= a_bank;
                    row_q  <= n_row;
                    col_q  <= a_col;
                    ack_q  <= (n_cmd == C_RD) || (n_cmd == C_WR);
                    if (state == S_IMRS) done_q <= 1'b1;
                end
            end
        end
    end

    // read-valid delay line, advanced once per memory tick
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pipe <= 3'b000;
            rdv_q   <= 1'b0;
        end else begin
            rdv_q <= 1'b0;
            if (tick) begin
                rd_pipe <= {rd_pipe[1:0], go && n_cmd == C_RD};
                rdv_q   <= rd_pipe[cl_eff - 3'd1];
            end
        end
    end

    assign cmd             = cmd_q;
    assign ba              = ba_q;
    assign row             = row_q;
    assign col             = col_q;
    assign req_ack         = ack_q;
    assign rd_valid        = rdv_q;
    assign init_done       = done_q;
    assign self_ref_active = (state == S_SELF);

    p_ack_is_rw_r11: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> (cmd_q == C_RD || cmd_q == C_WR));
    p_ack_single_r11: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);
    p_quiet_before_init_r1: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> (cmd_q == C_NOP || cmd_q == C_PALL || cmd_q == C_REF || cmd_q == C_MRS));
    p_self_nop_r12: assert property (@(posedge clk) disable iff (rst)
        (state == S_SELF && $past(state == S_SELF)) |-> (cmd_q == C_NOP));
endmodule

// File: tb/sdram_cmd_ctrl_test.sv
module sdram_cmd_ctrl_test;
    import sdr_pkg::*;
    localparam int ROW_W = 13;
    localparam int AW    = COL_MAX_W + BANK_W + ROW_W;
    localparam int RGAP  = 4;

    logic clk = 1'b0, rst = 1'b1;
    always #10 clk = ~clk;

    logic [1:0] f_cas = 2'd2, f_page = 2'd0;
    logic [3:0] f_tras = 4'd5;
    logic [2:0] f_trp = 3'd2, f_trcd = 3'd3;
    logic f_four = 1'b1, f_half = 1'b0;
    logic [15:0] ctrl;
    assign ctrl = {f_half, f_four, f_page, f_trcd, f_trp, f_tras, f_cas};

    logic [15:0] ref_interval = '0;
    logic init_go = 0, srf_req = 0, req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic req_ack, rd_valid, init_done, self_ref_active;
    logic [3:0] cmd;
    logic [1:0] ba;
    logic [ROW_W-1:0] row;
    logic [COL_MAX_W-1:0] col;

    sdram_cmd_ctrl #(.ROW_W(ROW_W), .REF_GAP(RGAP), .RI_W(16)) uut (
        .clk(clk), .rst(rst), .ctrl(ctrl), .ref_interval(ref_interval),
        .init_go(init_go), .srf_req(srf_req), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_ack(req_ack),
        .cmd(cmd), .ba(ba), .row(row), .col(col), .rd_valid(rd_valid),
        .init_done(init_done), .self_ref_active(self_ref_active)
    );

    int total = 0, bad = 0, cyc = 0;
    int n_cmd [16];
    int t_cmd [16];
    int m_ba [16];
    int m_row [16];
    int m_col [16];
    int n_rdv = 0, t_rdv = 0, t_ack = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && cmd != 4'd0) begin
            n_cmd[cmd] = n_cmd[cmd] + 1;
            t_cmd[cmd] = cyc;
            m_ba[cmd]  = int'(ba);
            m_row[cmd] = int'(row);
            m_col[cmd] = int'(col);
        end
        if (rd_valid) begin n_rdv = n_rdv + 1; t_rdv = cyc; end
        if (req_ack) t_ack = cyc;
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) if (cyc == 150000) begin
        total++; bad++;
        $display("FAIL R1 watchdog actual=%0d expected=<150000", cyc);
        summary();
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic int cb();
        return 8 + int'(f_page);
    endfunction
    function automatic int e_col(input logic [AW-1:0] a);
        return int'(a) & ((1 << cb()) - 1);
    endfunction
    function automatic int e_bank(input logic [AW-1:0] a);
        return (int'(a) >> cb()) & (f_four ? 3 : 1);
    endfunction
    function automatic int e_row(input logic [AW-1:0] a);
        return (int'(a) >> (cb() + (f_four ? 2 : 1))) & ((1 << ROW_W) - 1);
    endfunction
    function automatic int all_cmds();
        int s = 0;
        for (int i = 1; i < 16; i++) s += n_cmd[i];
        return s;
    endfunction

    task automatic acc(input bit wr, input logic [AW-1:0] a, output bit got);
        req_write = wr; req_addr = a; req_valid = 1'b1; got = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (req_ack) begin got = 1'b1; break; end
        end
        req_valid = 1'b0;
        chk("R11 ack seen", int'(got), 1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // {kind: 0 closed, 1 hit, 2 miss ; write ; addr = row<<10 | bank<<8 | col}
    localparam logic [28:0] VEC [8] = '{
        {2'd0, 1'b0, 3'd0, 13'd5,      2'd0, 8'h12},
        {2'd1, 1'b1, 3'd0, 13'd5,      2'd0, 8'h34},
        {2'd0, 1'b0, 3'd0, 13'd7,      2'd2, 8'hFF},
        {2'd2, 1'b1, 3'd0, 13'd9,      2'd0, 8'h01},
        {2'd1, 1'b0, 3'd0, 13'd7,      2'd2, 8'h00},
        {2'd2, 1'b0, 3'd0, 13'h1FFF,   2'd2, 8'h80},
        {2'd0, 1'b1, 3'd0, 13'd0,      2'd3, 8'h05},
        {2'd1, 1'b0, 3'd0, 13'd9,      2'd0, 8'h02}
    };

    initial begin
        bit got;
        int k, wr, rwc, a0, p0, r0, t_act, rf0, s0;
        logic [AW-1:0] a;

        repeat (3) @(negedge clk);
        chk("R1 cmd in reset", int'(cmd), 0);
        chk("R1 init_done in reset", int'(init_done), 0);
        rst = 1'b0;
        idle(1);
        chk("R1 ack after reset", int'(req_ack), 0);
        chk("R1 rd_valid after reset", int'(rd_valid), 0);
        idle(20);
        chk("R1 silent before start", all_cmds(), 0);

        init_go = 1'b1; @(negedge clk); init_go = 1'b0;
        idle(40);
        chk("R2 one precharge-all", n_cmd[C_PALL], 1);
        chk("R2 two refreshes", n_cmd[C_REF], 2);
        chk("R2 one mode write", n_cmd[C_MRS], 1);
        chk("R2 second refresh spacing", t_cmd[C_REF] - t_cmd[C_PALL], int'(f_trp) + RGAP);
        chk("R2 mode write spacing", t_cmd[C_MRS] - t_cmd[C_REF], RGAP);
        chk("R2 mode CAS field", (m_row[C_MRS] >> 4) & 7, 2);
        chk("R2 init_done", int'(init_done), 1);

        // table of accesses with default timing
        foreach (VEC[i]) begin
            k = int'(VEC[i][28:27]); wr = int'(VEC[i][26]); a = VEC[i][AW-1:0];
            a0 = n_cmd[C_ACT]; p0 = n_cmd[C_PRE]; r0 = n_rdv;
            acc(wr[0], a, got);
            idle(10);
            rwc = wr ? 3 : 2;
            chk("R4 column", m_col[rwc], e_col(a));
            chk("R4 bank", m_ba[rwc], e_bank(a));
            chk("R11 ack aligned", t_ack, t_cmd[rwc]);
            chk("R6 activates", n_cmd[C_ACT] - a0, (k == 1) ? 0 : 1);
            chk("R7 precharges", n_cmd[C_PRE] - p0, (k == 2) ? 1 : 0);
            if (k != 1) begin
                chk("R4 activate row", m_row[C_ACT], e_row(a));
                chk("R5 tRCD spacing", t_cmd[rwc] - t_cmd[C_ACT], eff(int'(f_trcd)));
            end
            if (k == 2) begin
                chk("R7 precharge bank", m_ba[C_PRE], e_bank(a));
                chk("R7 tRP spacing", t_cmd[C_ACT] - t_cmd[C_PRE], eff(int'(f_trp)));
            end
            chk("R8 valid count", n_rdv - r0, wr ? 0 : 1);
            if (!wr) chk("R8 CAS delay", t_rdv - t_cmd[C_RD], 2);
        end

        // tRAS longer than the activate-to-read path
        f_tras = 4'd12; f_trcd = 3'd1;
        acc(1'b0, {3'd0, 13'd3, 2'd1, 8'h00}, got);
        t_act = t_cmd[C_ACT];
        idle(1);
        acc(1'b0, {3'd0, 13'd4, 2'd1, 8'h00}, got);
        idle(10);
        chk("R7 tRAS hold before precharge", t_cmd[C_PRE] - t_act, 12);
        chk("R3 tRCD code 1", t_cmd[C_RD] - t_cmd[C_ACT], 1);
        f_tras = 4'd5; f_trcd = 3'd3;

        // CAS latency codes, and a write gives no strobe
        f_cas = 2'd1; acc(1'b0, {3'd0, 13'd4, 2'd1, 8'h01}, got); idle(10);
        chk("R8 CAS 1", t_rdv - t_cmd[C_RD], 1);
        f_cas = 2'd3; acc(1'b0, {3'd0, 13'd4, 2'd1, 8'h02}, got); idle(10);
        chk("R8 CAS 3", t_rdv - t_cmd[C_RD], 3);
        f_cas = 2'd0; acc(1'b0, {3'd0, 13'd4, 2'd1, 8'h03}, got); idle(10);
        chk("R3 CAS code 0 as 1", t_rdv - t_cmd[C_RD], 1);
        f_cas = 2'd2; r0 = n_rdv;
        acc(1'b1, {3'd0, 13'd4, 2'd1, 8'h04}, got); idle(10);
        chk("R8 no strobe on write", n_rdv - r0, 0);

        // 2048-word page with two banks
        f_page = 2'd3; f_four = 1'b0;
        a = AW'(32'h33DA5);
        acc(1'b0, a, got); idle(10);
        chk("R4 wide column", m_col[C_RD], 32'h5A5);
        chk("R4 two-bank select", m_ba[C_RD], 1);
        chk("R4 two-bank row", m_row[C_ACT], 32'h33);
        f_page = 2'd0; f_four = 1'b1;

        // half-rate memory clock
        f_half = 1'b1;
        acc(1'b0, {3'd0, 13'd1, 2'd3, 8'h00}, got); idle(16);
        chk("R9 tRP doubled", t_cmd[C_ACT] - t_cmd[C_PRE], 4);
        chk("R9 tRCD doubled", t_cmd[C_RD] - t_cmd[C_ACT], 6);
        chk("R9 CAS doubled", t_rdv - t_cmd[C_RD], 4);
        f_half = 1'b0;
        idle(4);

        // refresh disabled by a zero interval
        rf0 = n_cmd[C_REF];
        idle(200);
        chk("R10 zero interval", n_cmd[C_REF] - rf0, 0);

        // pending refresh wins over a waiting request
        rf0 = n_cmd[C_REF]; p0 = n_cmd[C_PALL]; a0 = n_cmd[C_ACT];
        ref_interval = 16'd1;
        @(negedge clk);
        ref_interval = 16'd0;
        acc(1'b0, {3'd0, 13'd1, 2'd3, 8'h07}, got);
        idle(10);
        chk("R10 refresh issued", n_cmd[C_REF] - rf0, 1);
        chk("R10 rows closed first", n_cmd[C_PALL] - p0, 1);
        chk("R10 tRP before refresh", t_cmd[C_REF] - t_cmd[C_PALL], 2);
        chk("R10 refresh before access", int'(t_cmd[C_REF] < t_cmd[C_RD]), 1);
        chk("R10 row reopened", n_cmd[C_ACT] - a0, 1);

        // self refresh
        p0 = n_cmd[C_PALL]; k = n_cmd[C_SRE];
        srf_req = 1'b1;
        idle(20);
        chk("R12 rows closed", n_cmd[C_PALL] - p0, 1);
        chk("R12 enter issued", n_cmd[C_SRE] - k, 1);
        chk("R12 active flag", int'(self_ref_active), 1);
        s0 = all_cmds();
        idle(30);
        chk("R12 held quiet", all_cmds() - s0, 0);
        srf_req = 1'b0;
        idle(10);
        chk("R12 exit issued", n_cmd[C_SRX], 1);
        chk("R12 flag cleared", int'(self_ref_active), 0);
        acc(1'b1, {3'd0, 13'd2, 2'd0, 8'h09}, got);
        idle(5);
        chk("R12 resumes", m_col[C_WR], 9);

        summary();
        $finish;
    end
endmodule